// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block sits between a UART's serial deserializer and its register interface. It buffers incoming bytes in a 16-entry first-in first-out store and tracks the receive-side line status: data ready, overrun and break. It also tells the interrupt logic two things. One is when the number of stored bytes has reached a programmable threshold. The other is when bytes have been left sitting unread for four character times. Software may instead switch the queue off. The block then falls back to a single holding register.

The surrounding UART drives the block with four kinds of event:
- a strobe per received byte, or per detected break;
- a strobe per read of the receive buffer;
- a write port for the queue-control byte;
- a strobe per read of the line-status register.

The length of one character, in clock cycles, comes from outside the block, because it depends on the baud divisor and the frame format, and both of those are held elsewhere. The byte that a read would return is visible on `rd_data` before the read strobe. The strobe then pops it at the clock edge.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, the queue is disabled, `level` is 0, `dr`, `oe`, `bi`, `tmo_pend` and `trig_hit` are 0, and `rd_data` is 0x00.
- R2: With the queue enabled (control bit 0 = 1), bytes are returned in arrival order. `rd_data` shows the oldest byte before the read strobe, and `level` counts the stored bytes.
- R3: Control bits 7:6 pick the threshold: 00 = 1 byte, 01 = 4 bytes, 10 = 8 bytes, 11 = 14 bytes. In queue mode, `trig_hit` is 1 exactly when `level` is at least the threshold.
- R4: A byte that arrives while 16 bytes are stored, with no read in the same cycle, is dropped. The stored bytes stay unchanged and `oe` is set.
- R5: With the queue disabled, each byte replaces the holding register and sets `dr`, and `rd_data` shows that register. If a byte arrives while `dr` is already set, `oe` is set. A read clears `dr`, and `trig_hit` follows `dr`. `level` stays 0.
- R6: In queue mode, a countdown of four times `char_cycles` restarts on every received byte, and on every read that leaves data behind. `tmo_pend` rises on the clock edge that ends the countdown, but only if data is stored. Any read clears it. In holding-register mode it never rises.
- R7: A read of an empty queue returns 0x00 and changes nothing. A read that removes the last byte clears `dr` and `bi`.
- R8: A break strobe stores a 0x00 byte and sets both `bi` and `dr`.
- R9: A line-status read clears `bi` and `oe`.
- R10: A control write with bit 1 set, or one that changes bit 0, empties the queue, clears `dr`, `bi` and `tmo_pend`, and cancels the countdown. It leaves `oe` as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| brk_valid | input | 1 | A break was detected; takes precedence over rx_valid |
| rd_stb | input | 1 | Read of the receive buffer |
| ctl_wr | input | 1 | Write of the queue-control byte |
| ctl_data | input | 8 | Control byte: bit 0 enable, bit 1 flush, bits 7:6 threshold |
| lsr_rd | input | 1 | Read of the line-status register |
| char_cycles | input | CT_W | Clock cycles per character |
| rd_data | output | 8 | Byte that a read returns now |
| level | output | $clog2(DEPTH+1) | Number of stored bytes |
| trig_hit | output | 1 | Threshold reached, or data ready in holding-register mode |
| tmo_pend | output | 1 | Character timeout pending |
| dr | output | 1 | Data ready |
| oe | output | 1 | Overrun |
| bi | output | 1 | Break seen |

## Verification
The bench fills the queue up to each of the four thresholds in turn. Stopping one byte short of each threshold, and then adding that byte, separates a correct threshold decode from an off-by-one or a swapped code. Pushing past sixteen and then draining through the scoreboard shows whether an overrun drops the newest byte or overwrites a stored one. Timed waits of one cycle short of and exactly four character times, after a receive, after a partial read and after an emptying read, pin down the reload and the empty-queue gating. Breaks, flushes by bit and by mode change, and a run in holding-register mode check the status bits against each event that sets or clears them.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

   localparam int RXQ_DEPTH     = 16;
   localparam int TRIG_MAX      = 14;
   localparam int CTL_EN_BIT    = 0;
   localparam int CTL_FLUSH_BIT = 1;
   localparam int CTL_TRIG_LSB  = 6;

   typedef logic [7:0] rxq_byte_t;

   typedef enum logic [1:0] {
      TRIG_ONE      = 2'b00,
      TRIG_FOUR     = 2'b01,
      TRIG_EIGHT    = 2'b10,
      TRIG_FOURTEEN = 2'b11
   } rxq_trig_e;

   function automatic int trig_depth(input rxq_trig_e sel);
      case (sel)
         TRIG_ONE:   return 1;
         TRIG_FOUR:  return 4;
         TRIG_EIGHT: return 8;
         default:    return TRIG_MAX;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_store: DEPTH must be at least 2");
      end
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_inc = wr_ptr + AW'(1);
         assign rd_inc = rd_ptr + AW'(1);
      end else begin : g_wrap
         assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_inc;
         if (pop)  rd_ptr <= rd_inc;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign head  = mem[rd_ptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full);

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));

endmodule

// File: rtl/rxq_timer.sv
`timescale 1ns/1ps
module rxq_timer #(
   parameter int CT_W = 16,
   localparam int TW  = CT_W + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reload,
   input  logic            stop,
   input  logic            clr,
   input  logic            nonempty,
   input  logic [CT_W-1:0] char_cycles,
   output logic            pend
);

   logic [TW-1:0] cnt;
   logic          armed;
   logic          expire;

   generate
      if (CT_W < 1) begin : g_bad_width
         $error("rxq_timer: CT_W must be at least 1");
      end
   endgenerate

   assign expire = armed && !stop && !reload && (cnt <= TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         pend  <= 1'b0;
      end else begin
         if (stop) begin
            armed <= 1'b0;
         end else if (reload) begin
            armed <= 1'b1;
            cnt   <= {char_cycles, 2'b00};
         end else if (armed) begin
            if (cnt <= TW'(1)) armed <= 1'b0;
            else               cnt   <= cnt - TW'(1);
         end
         if (clr)                        pend <= 1'b0;
         else if (expire && nonempty)    pend <= 1'b1;
      end
   end

   // R6
   pend_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> nonempty);

   // R10
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop && clr |=> !pend);

endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue import rxq_pkg::*; #(
   parameter int DEPTH = RXQ_DEPTH,
   parameter int CT_W  = 16,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   input  logic            brk_valid,
   input  logic            rd_stb,
   input  logic            ctl_wr,
   input  logic [7:0]      ctl_data,
   input  logic            lsr_rd,
   input  logic [CT_W-1:0] char_cycles,
   output logic [7:0]      rd_data,
   output logic [LW-1:0]   level,
   output logic            trig_hit,
   output logic            tmo_pend,
   output logic            dr,
   output logic            oe,
   output logic            bi
);

   generate
      if (DEPTH < TRIG_MAX) begin : g_bad_depth
         $error("uart_rx_queue: DEPTH must hold the largest threshold");
      end
   endgenerate

   logic          fifo_on;
   rxq_trig_e     trig_sel;
   rxq_byte_t     hold_q, in_byte, head;
   logic [LW-1:0] cnt, thr;
   logic          flush, any_in, fifo_in, hold_ld;
   logic          push, pop, full, empty, last_pop, ovr;
   logic          t_reload, t_stop, t_clr;
   logic          unused_ctl;

   assign unused_ctl = ^ctl_data[5:2];

   assign flush    = ctl_wr && (ctl_data[CTL_FLUSH_BIT] ||
                                (ctl_data[CTL_EN_BIT] != fifo_on));
   assign any_in   = (rx_valid || brk_valid) && !flush;
   assign in_byte  = brk_valid ? '0 : rx_data;
   assign fifo_in  = any_in && fifo_on;
   assign hold_ld  = any_in && !fifo_on;
   assign pop      = rd_stb && fifo_on && !empty && !flush;
   assign push     = fifo_in && (!full || pop);
   assign last_pop = pop && !push && (cnt == LW'(1));
   assign ovr      = (fifo_in && full && !pop) || (hold_ld && dr && !rd_stb);

   rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .push  (push),
      .pop   (pop),
      .din   (in_byte),
      .head  (head),
      .count (cnt),
      .full  (full),
      .empty (empty)
   );

   assign t_reload = (fifo_on && !flush && rx_valid && !brk_valid) ||
                     (pop && ((cnt > LW'(1)) || push));
   assign t_stop   = flush || last_pop;
   assign t_clr    = rd_stb || flush;

   rxq_timer #(.CT_W(CT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload      (t_reload),
      .stop        (t_stop),
      .clr         (t_clr),
      .nonempty    (!empty),
      .char_cycles (char_cycles),
      .pend        (tmo_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_on  <= 1'b0;
         trig_sel <= TRIG_ONE;
         hold_q   <= '0;
         dr       <= 1'b0;
         oe       <= 1'b0;
         bi       <= 1'b0;
      end else begin
         if (ctl_wr) begin
            fifo_on  <= ctl_data[CTL_EN_BIT];
            trig_sel <= rxq_trig_e'(ctl_data[CTL_TRIG_LSB +: 2]);
         end
         if (hold_ld) hold_q <= in_byte;

         if (flush)                                   dr <= 1'b0;
         else if (push || hold_ld)                    dr <= 1'b1;
         else if (last_pop || (rd_stb && !fifo_on))   dr <= 1'b0;

         if (flush)                                   bi <= 1'b0;
         else if (brk_valid && any_in)                bi <= 1'b1;
         else if (lsr_rd || last_pop || (rd_stb && !fifo_on))
                                                      bi <= 1'b0;

         if (ovr)         oe <= 1'b1;
         else if (lsr_rd) oe <= 1'b0;
      end
   end

   assign thr      = LW'(trig_depth(trig_sel));
   assign trig_hit = fifo_on ? (cnt >= thr) : dr;
   assign rd_data  = fifo_on ? (empty ? '0 : head) : hold_q;
   assign level    = cnt;

   // R2
   dr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on |-> (dr == (level != '0)));

   // R5
   hold_mode_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> (level == '0) && !tmo_pend);

   // R9
   lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd && !rx_valid && !brk_valid |=> !oe && !bi);

   // R10
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_data[CTL_FLUSH_BIT] |=> (level == '0) && !dr && !bi && !tmo_pend);

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !tmo_pend);

endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;

   localparam int DEPTH = 16;
   localparam int CT_W  = 16;
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int CHR   = 5;
   localparam int TMO   = 4 * CHR;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rx_valid = 1'b0;
   logic [7:0]      rx_data = '0;
   logic            brk_valid = 1'b0;
   logic            rd_stb = 1'b0;
   logic            ctl_wr = 1'b0;
   logic [7:0]      ctl_data = '0;
   logic            lsr_rd = 1'b0;
   logic [CT_W-1:0] char_cycles = CT_W'(CHR);
   logic [7:0]      rd_data;
   logic [LW-1:0]   level;
   logic            trig_hit, tmo_pend, dr, oe, bi;

   always #10 clk = ~clk;

   uart_rx_queue #(.DEPTH(DEPTH), .CT_W(CT_W)) i_uart_rx_queue (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .brk_valid(brk_valid), .rd_stb(rd_stb), .ctl_wr(ctl_wr),
      .ctl_data(ctl_data), .lsr_rd(lsr_rd), .char_cycles(char_cycles),
      .rd_data(rd_data), .level(level), .trig_hit(trig_hit),
      .tmo_pend(tmo_pend), .dr(dr), .oe(oe), .bi(bi)
   );

   int         checks = 0;
   int         fails  = 0;
   logic [7:0] exp_q[$];
   int         mdl_lvl = 0;
   logic       mdl_fifo = 1'b0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: byte into the design, expected copy into the scoreboard
   task automatic send(logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_data = b;
      @(negedge clk); rx_valid = 1'b0;
      if (mdl_fifo && mdl_lvl < DEPTH) begin
         exp_q.push_back(b);
         mdl_lvl++;
      end
   endtask

   task automatic send_brk();
      @(negedge clk); brk_valid = 1'b1;
      @(negedge clk); brk_valid = 1'b0;
      if (mdl_fifo && mdl_lvl < DEPTH) begin
         exp_q.push_back(8'h00);
         mdl_lvl++;
      end
   endtask

   task automatic wr_ctl(logic [7:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
      @(negedge clk); ctl_wr = 1'b0;
      if (v[1] || (v[0] != mdl_fifo)) begin
         exp_q.delete();
         mdl_lvl = 0;
      end
      mdl_fifo = v[0];
   endtask

   task automatic lsr_read();
      @(negedge clk); lsr_rd = 1'b1;
      @(negedge clk); lsr_rd = 1'b0;
   endtask

   task automatic rd_pulse(output logic [7:0] got);
      @(negedge clk); got = rd_data; rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   // monitor: compare what the design hands out with the scoreboard head
   task automatic read_pop(string req);
      logic [7:0] got, exp;
      rd_pulse(got);
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      if (mdl_lvl > 0) mdl_lvl--;
      chk(req, got, exp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [7:0] got;
      int thr;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      chk("R1 level", level, 0);
      chk("R1 flags", {dr, oe, bi, tmo_pend, trig_hit}, 0);
      chk("R1 rd_data", rd_data, 8'h00);

      // R2 basic order
      wr_ctl(8'h01);
      send(8'h3C); send(8'h5A); send(8'hC3);
      chk("R2 level", level, 3);
      chk("R2 dr", dr, 1);
      read_pop("R2 order");
      read_pop("R2 order");
      read_pop("R2 order");
      chk("R7 dr after last read", dr, 0);
      read_pop("R7 empty read");
      chk("R7 level after empty read", level, 0);

      // R3 thresholds, R4 overrun, R9 status read
      for (int s = 0; s < 4; s++) begin
         thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
         wr_ctl(8'(s << 6) | 8'h03);
         for (int i = 0; i < thr - 1; i++) send(8'(s * 32 + i + 1));
         if (thr > 1) chk("R3 below threshold", trig_hit, 0);
         send(8'(s * 32 + thr + 1));
         chk("R3 at threshold", trig_hit, 1);
         chk("R3 level", level, thr);
         if (s == 3) begin
            send(8'hD1); send(8'hD2);
            chk("R4 full level", level, DEPTH);
            chk("R4 oe before", oe, 0);
            send(8'hEE);
            chk("R4 oe", oe, 1);
            chk("R4 level kept", level, DEPTH);
            lsr_read();
            chk("R9 oe cleared", oe, 0);
         end
         while (exp_q.size() > 0) read_pop("R4 R2 drain");
      end

      // R6 timeout
      wr_ctl(8'h03);
      send(8'hA1); send(8'hA2);
      wait_n(TMO - 1);
      chk("R6 not yet", tmo_pend, 0);
      wait_n(1);
      chk("R6 expiry", tmo_pend, 1);
      read_pop("R6 read");
      chk("R6 read clears", tmo_pend, 0);
      wait_n(TMO - 1);
      chk("R6 reload not yet", tmo_pend, 0);
      wait_n(1);
      chk("R6 reload expiry", tmo_pend, 1);
      read_pop("R6 last read");
      wait_n(TMO + 5);
      chk("R6 empty no pend", tmo_pend, 0);

      // R8 break
      send_brk();
      chk("R8 bi", bi, 1);
      chk("R8 dr", dr, 1);
      chk("R8 level", level, 1);
      chk("R8 data", rd_data, 8'h00);
      lsr_read();
      chk("R9 bi cleared", bi, 0);
      chk("R9 dr kept", dr, 1);
      read_pop("R8 null byte");
      send_brk();
      read_pop("R8 null byte");
      chk("R7 bi after last read", bi, 0);
      chk("R7 dr after last read", dr, 0);

      // R10 flush
      for (int i = 0; i < DEPTH + 1; i++) send(8'(8'h40 + i));
      chk("R10 pre oe", oe, 1);
      wr_ctl(8'h03);
      chk("R10 level", level, 0);
      chk("R10 dr", dr, 0);
      chk("R10 oe kept", oe, 1);
      wait_n(TMO + 3);
      chk("R10 no timeout", tmo_pend, 0);
      lsr_read();
      send(8'h61); send(8'h62);
      wr_ctl(8'h00);
      chk("R10 mode change level", level, 0);
      chk("R10 mode change dr", dr, 0);

      // R5 holding-register mode
      send(8'h11);
      chk("R5 dr", dr, 1);
      chk("R5 trig", trig_hit, 1);
      chk("R5 data", rd_data, 8'h11);
      chk("R5 level", level, 0);
      chk("R5 no oe", oe, 0);
      send(8'h22);
      chk("R5 oe", oe, 1);
      chk("R5 newest", rd_data, 8'h22);
      rd_pulse(got);
      chk("R5 read data", got, 8'h22);
      chk("R5 dr cleared", dr, 0);
      send(8'h33);
      wait_n(TMO + 3);
      chk("R6 no timeout when disabled", tmo_pend, 0);

      summary();
   end

endmodule